// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Fractional Dithering

This block is a single channel of a general-purpose timer. The free-running counter is supplied from outside. The channel works either as an output compare or as an input capture.

- **Output compare.** Software writes a compare word into a visible register. That word reaches the active compare register in one of two ways:
  - at the next clock edge, when preload is off;
  - at the next update event, when preload is on.
- **PWM output.** The active value, or a dithered version of it, is compared with the counter to produce a PWM mode 1 output. The output is high while the counter is below the effective compare value.
- **Dithering.** With dithering on, the low four bits of the compare word are a fraction F. Over each run of sixteen update periods, exactly F periods are lengthened by one count. A bit-reversed period index spreads those periods evenly.
- **Input capture.** The visible register records the counter on every capture event, and software writes are dropped. A capture flag state machine tracks unread and overwritten captures.

A mode state machine has three named states:

| State | Meaning |
|---|---|
| `MD_OFF` | Channel disabled |
| `MD_CMP` | Output compare |
| `MD_CAP` | Input capture |

Mode transitions:
- `MD_OFF` to `MD_CMP`: on enable, when the capture configuration bit is low.
- `MD_OFF` to `MD_CAP`: on enable, when the capture configuration bit is high.
- `MD_CMP` or `MD_CAP` back to `MD_OFF`: when enable drops.

The configuration bits are latched only while the channel is in `MD_OFF`.

The capture flag machine has three named states:

| State | Meaning |
|---|---|
| `CF_EMPTY` | No unread capture |
| `CF_HELD` | One unread capture |
| `CF_OVER` | A capture was overwritten before it was read |

Capture flag transitions:
- `CF_EMPTY` to `CF_HELD`: on a capture.
- `CF_HELD` to `CF_OVER`: on a capture with no read in the same cycle.
- `CF_OVER` stays in `CF_OVER`: on a further capture with no read.
- Any state to `CF_HELD`: on a capture and a read in the same cycle.
- Any state to `CF_EMPTY`: on a read alone, or whenever the mode is not `MD_CAP`.

Top module: `ccx_channel`

## Requirements
- R1: After reset, `rd_data` is 0, `cmp_out` is 0, and `cap_pend` and `ovr_cap` are 0.
- R2: With preload latched off and the mode not `MD_CAP`, a write (`wr_en`) loads both the visible register and the active compare value at the next clock edge.
- R3: With preload latched on, a write changes only the visible register. The active value takes the visible register's content at an update event. When a write and an update arrive in the same cycle, the active value takes the content from before the write.
- R4: `cmp_out` is 1 exactly when the mode is `MD_CMP` and `counter` is below the effective compare value. In every other mode it is 0.
- R5: With dithering latched off, the effective compare value is the full 32-bit active value.
- R6: With dithering latched on:
  - The effective value is `active[31:4]`, plus one when the bit-reverse of the 4-bit period index is below F = `active[3:0]`.
  - The index is 0 in `MD_OFF`.
  - The index increments, wrapping at 16, on each `update_evt` in `MD_CMP`.
- R7: In `MD_CAP`, a `capture_evt` stores `counter` into the visible register, and writes are ignored.
- R8: In `MD_CAP` with dithering latched on, a capture stores `counter` with bits [3:0] forced to 0.
- R9: `cap_pend` and `ovr_cap` follow the capture flag machine described above:
  - `cap_pend` is 1 in `CF_HELD` and `CF_OVER`.
  - `ovr_cap` is 1 only in `CF_OVER`.
- R10: The configuration inputs are sampled only in `MD_OFF`. Changing them while enabled has no effect.
- R11: The mode follows `chan_en` one clock later. Leaving `MD_CAP` returns the flags to `CF_EMPTY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| cfg_capture | input | 1 | 1 selects input capture, 0 selects output compare |
| cfg_preload | input | 1 | Preload enable for the compare value |
| cfg_dither | input | 1 | Fractional dithering enable |
| wr_en | input | 1 | Software write strobe for the visible register |
| wr_data | input | 32 | Software write data |
| rd_en | input | 1 | Software read strobe (clears capture flags) |
| rd_data | output | 32 | Visible register contents |
| counter | input | 32 | Timer counter value |
| update_evt | input | 1 | Timer update event |
| capture_evt | input | 1 | Capture trigger |
| cmp_out | output | 1 | Compare output (PWM mode 1) |
| cap_pend | output | 1 | Unread capture flag |
| ovr_cap | output | 1 | Overcapture flag |

## Verification
The hardest situation to reach is a full sixteen-period dither cycle in which the extended periods can be told apart at the compare output. The stimulus reaches it by holding `counter` exactly at the integer part while it issues sixteen update events, so each period shows directly whether the one-count extension applied. The other hard cases are coincident events: a write in the same cycle as an update under preload, and a capture in the same cycle as a read. Directed steps force both, and a long random phase with toggled enables and random configuration revisits them together with configuration changes made while the channel is enabled.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

    typedef enum logic [1:0] {
        MD_OFF = 2'd0,
        MD_CMP = 2'd1,
        MD_CAP = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        CF_EMPTY = 2'd0,
        CF_HELD  = 2'd1,
        CF_OVER  = 2'd2
    } capf_e;

    typedef struct packed {
        logic capture;
        logic preload;
        logic dither;
    } chan_cfg_t;

endpackage

// File: rtl/ccx_mode_fsm.sv
module ccx_mode_fsm
    import ccx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  chan_cfg_t cfg_in,
    output mode_e     mode,
    output chan_cfg_t cfg_q
);

    mode_e mode_q, mode_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_OFF;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MD_OFF: begin
                if (en) begin
                    mode_d = cfg_in.capture ? MD_CAP : MD_CMP;
                end
            end
            MD_CMP: begin
                if (!en) begin
                    mode_d = MD_OFF;
                end
            end
            MD_CAP: begin
                if (!en) begin
                    mode_d = MD_OFF;
                end
            end
            default: mode_d = MD_OFF;
        endcase
    end

    // Configuration is only sampled while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (mode_q == MD_OFF) begin
            cfg_q <= cfg_in;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/ccx_shadow_reg.sv
module ccx_shadow_reg
    import ccx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              dither,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] counter,
    input  logic              capture_evt,
    output logic [DATA_W-1:0] value,
    output logic              cap_pend,
    output logic              ovr_cap
);

    localparam int INT_W = DATA_W - FRAC_W;

    logic [DATA_W-1:0] value_q;
    logic [DATA_W-1:0] cap_word;
    capf_e             flag_q, flag_d;
    logic              cap_take;

    assign cap_take = (mode == MD_CAP) && capture_evt;
    assign cap_word = dither ? {counter[DATA_W-1:FRAC_W], {FRAC_W{1'b0}}} : counter;

    // Visible register: captures in input mode, software writes otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (mode == MD_CAP) begin
            if (capture_evt) begin
                value_q <= cap_word;
            end
        end else if (wr_en) begin
            value_q <= wr_data;
        end
    end

    // Capture flag state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= CF_EMPTY;
        end else begin
            flag_q <= flag_d;
        end
    end

    // Capture flag next-state logic
    always_comb begin
        flag_d = flag_q;
        if (mode != MD_CAP) begin
            flag_d = CF_EMPTY;
        end else begin
            unique case (flag_q)
                CF_EMPTY: begin
                    if (cap_take) flag_d = CF_HELD;
                end
                CF_HELD: begin
                    if (cap_take && rd_en)  flag_d = CF_HELD;
                    else if (cap_take)      flag_d = CF_OVER;
                    else if (rd_en)         flag_d = CF_EMPTY;
                end
                CF_OVER: begin
                    if (cap_take && rd_en)  flag_d = CF_HELD;
                    else if (rd_en)         flag_d = CF_EMPTY;
                end
                default: flag_d = CF_EMPTY;
            endcase
        end
    end

    // Flag outputs
    always_comb begin
        cap_pend = 1'b0;
        ovr_cap  = 1'b0;
        unique case (flag_q)
            CF_EMPTY: ;
            CF_HELD:  cap_pend = 1'b1;
            CF_OVER: begin
                cap_pend = 1'b1;
                ovr_cap  = 1'b1;
            end
            default: ;
        endcase
    end

    assign value = value_q;

    logic unused_int;
    assign unused_int = ^{INT_W{1'b0}};

endmodule

// File: rtl/ccx_cmp_path.sv
module ccx_cmp_path
    import ccx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              preload,
    input  logic              dither,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] shadow,
    input  logic              update_evt,
    input  logic [DATA_W-1:0] counter,
    output logic [DATA_W-1:0] active,
    output logic [FRAC_W-1:0] phase,
    output logic              cmp_out
);

    localparam int INT_W = DATA_W - FRAC_W;

    logic [DATA_W-1:0] active_q;
    logic [FRAC_W-1:0] phase_q;
    logic [FRAC_W-1:0] phase_rev;
    logic              stretch;
    logic [DATA_W-1:0] int_part;
    logic [DATA_W-1:0] eff;

    // Active compare register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (mode != MD_CAP) begin
            if (!preload && wr_en) begin
                active_q <= wr_data;
            end else if (preload && update_evt) begin
                active_q <= shadow;
            end
        end
    end

    // Dither period index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (mode == MD_OFF) begin
            phase_q <= '0;
        end else if (mode == MD_CMP && dither && update_evt) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Bit reversal of the period index
    for (genvar g = 0; g < FRAC_W; g++) begin : g_rev
        assign phase_rev[g] = phase_q[FRAC_W-1-g];
    end

    assign stretch  = phase_rev < active_q[FRAC_W-1:0];
    assign int_part = {{FRAC_W{1'b0}}, active_q[DATA_W-1:FRAC_W]};

    always_comb begin
        if (dither) begin
            eff = int_part + DATA_W'(stretch);
        end else begin
            eff = active_q;
        end
    end

    assign cmp_out = (mode == MD_CMP) && (counter < eff);
    assign active  = active_q;
    assign phase   = phase_q;

    logic unused_w;
    assign unused_w = ^{INT_W{1'b0}};

endmodule

// File: rtl/ccx_channel.sv
module ccx_channel
    import ccx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              cfg_capture,
    input  logic              cfg_preload,
    input  logic              cfg_dither,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] counter,
    input  logic              update_evt,
    input  logic              capture_evt,
    output logic              cmp_out,
    output logic              cap_pend,
    output logic              ovr_cap
);

    chan_cfg_t         cfg_in;
    chan_cfg_t         cfg_q;
    mode_e             mode_q;
    logic [DATA_W-1:0] shadow_val;
    logic [DATA_W-1:0] act_val;
    logic [FRAC_W-1:0] phase_idx;

    assign cfg_in = '{capture: cfg_capture, preload: cfg_preload, dither: cfg_dither};

    ccx_mode_fsm u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (chan_en),
        .cfg_in (cfg_in),
        .mode   (mode_q),
        .cfg_q  (cfg_q)
    );

    ccx_shadow_reg #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .dither      (cfg_q.dither),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .counter     (counter),
        .capture_evt (capture_evt),
        .value       (shadow_val),
        .cap_pend    (cap_pend),
        .ovr_cap     (ovr_cap)
    );

    ccx_cmp_path #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .preload    (cfg_q.preload),
        .dither     (cfg_q.dither),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .shadow     (shadow_val),
        .update_evt (update_evt),
        .counter    (counter),
        .active     (act_val),
        .phase      (phase_idx),
        .cmp_out    (cmp_out)
    );

    assign rd_data = shadow_val;

endmodule

// File: rtl/ccx_channel_chk.sv
module ccx_channel_chk
    import ccx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input mode_e             mode_q,
    input chan_cfg_t         cfg_q,
    input logic              wr_en,
    input logic              update_evt,
    input logic              capture_evt,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] act_val,
    input logic [FRAC_W-1:0] phase_idx,
    input logic              cmp_out,
    input logic              cap_pend,
    input logic              ovr_cap
);

    AST_OUT_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_out |-> (mode_q == MD_CMP)); // R4

    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_CMP && cfg_q.preload && !update_evt) |=> $stable(act_val)); // R3

    AST_DITHER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_CMP && cfg_q.dither && update_evt) |=> (phase_idx == FRAC_W'($past(phase_idx) + 1'b1))); // R6

    AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_CAP && wr_en && !capture_evt) |=> $stable(rd_data)); // R7

    AST_CAP_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_CAP && cfg_q.dither && capture_evt) |=> (rd_data[FRAC_W-1:0] == '0)); // R8

    AST_OVR_IMPLIES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_cap |-> cap_pend); // R9

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MD_OFF) |=> $stable(cfg_q)); // R10

    AST_FLAGS_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MD_CAP) |=> !cap_pend); // R11

endmodule

bind ccx_channel ccx_channel_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .cfg_q       (cfg_q),
    .wr_en       (wr_en),
    .update_evt  (update_evt),
    .capture_evt (capture_evt),
    .rd_data     (rd_data),
    .act_val     (act_val),
    .phase_idx   (phase_idx),
    .cmp_out     (cmp_out),
    .cap_pend    (cap_pend),
    .ovr_cap     (ovr_cap)
);

// File: tb/sim_ccx_channel.sv
`timescale 1ns/1ps
module sim_ccx_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0, cfg_capture = 1'b0, cfg_preload = 1'b0, cfg_dither = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, update_evt = 1'b0, capture_evt = 1'b0;
    logic [31:0] wr_data = '0, counter = '0;
    logic [31:0] rd_data;
    logic        cmp_out, cap_pend, ovr_cap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    int          m_mode = 0;  // 0 off, 1 compare, 2 capture
    int          m_flag = 0;  // 0 empty, 1 held, 2 over
    logic [31:0] m_reg = '0, m_act = '0;
    logic [3:0]  m_idx = '0;
    bit          m_cap = 0, m_pre = 0, m_dit = 0;

    always #10 clk = ~clk;

    ccx_channel u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_capture(cfg_capture),
        .cfg_preload(cfg_preload), .cfg_dither(cfg_dither), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .counter(counter),
        .update_evt(update_evt), .capture_evt(capture_evt), .cmp_out(cmp_out),
        .cap_pend(cap_pend), .ovr_cap(ovr_cap)
    );

    function automatic logic [3:0] rev4(input logic [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    function automatic logic [31:0] eff_of(input logic [31:0] a, input bit dit, input logic [3:0] idx);
        if (!dit) return a;
        return {4'b0, a[31:4]} + ((rev4(idx) < a[3:0]) ? 32'd1 : 32'd0);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [31:0] n_reg, n_act;
        n_reg = m_reg;
        n_act = m_act;
        if (m_mode == 2) begin
            if (capture_evt) n_reg = m_dit ? {counter[31:4], 4'b0} : counter;
        end else begin
            if (wr_en) n_reg = wr_data;
            if (!m_pre && wr_en) n_act = wr_data;
            else if (m_pre && update_evt) n_act = m_reg;
        end
        if (m_mode == 0) m_idx = '0;
        else if (m_mode == 1 && m_dit && update_evt) m_idx = m_idx + 1'b1;
        if (m_mode != 2) m_flag = 0;
        else if (capture_evt && rd_en) m_flag = 1;
        else if (capture_evt) m_flag = (m_flag == 0) ? 1 : 2;
        else if (rd_en) m_flag = 0;
        if (m_mode == 0) begin
            m_cap = cfg_capture; m_pre = cfg_preload; m_dit = cfg_dither;
            if (chan_en) m_mode = cfg_capture ? 2 : 1;
        end else if (!chan_en) begin
            m_mode = 0;
        end
        m_reg = n_reg;
        m_act = n_act;
    endtask

    // One cycle: inputs already set by caller before negedge; check, then clock
    task automatic cyc(input string tag);
        @(negedge clk);
        #1;
        chk(tag, "rd_data", rd_data, m_reg);
        chk(tag, "cmp_out", {31'b0, cmp_out}, {31'b0, (m_mode == 1) && (counter < eff_of(m_act, m_dit, m_idx))});
        chk(tag, "cap_pend", {31'b0, cap_pend}, {31'b0, m_flag != 0});
        chk(tag, "ovr_cap", {31'b0, ovr_cap}, {31'b0, m_flag == 2});
        @(posedge clk);
        model_edge();
        #2;
        wr_en = 0; rd_en = 0; update_evt = 0; capture_evt = 0;
    endtask

    task automatic enter(input bit cap, input bit pre, input bit dit, input string tag);
        chan_en = 0; cfg_capture = cap; cfg_preload = pre; cfg_dither = dit;
        cyc(tag);
        cyc(tag);
        chan_en = 1;
        cyc(tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1: reset state
        cyc("R1");
        chk("R1", "rd_data reset", rd_data, 32'h0);

        // R11 enter compare mode, R2 immediate load, R5 full-width compare
        enter(0, 0, 0, "R11");
        wr_data = 32'd100; wr_en = 1; counter = 32'd99; cyc("R2");
        counter = 32'd99;  cyc("R2");
        counter = 32'd100; cyc("R2");
        wr_data = 32'h13; wr_en = 1; cyc("R5");
        counter = 32'd18; cyc("R5");
        counter = 32'd19; cyc("R5");
        // R10 config changes while enabled have no effect
        cfg_dither = 1; cfg_capture = 1; cfg_preload = 1;
        wr_data = 32'd40; wr_en = 1; counter = 32'd30; cyc("R10");
        counter = 32'd39; cyc("R10");
        counter = 32'd40; capture_evt = 1; cyc("R10");

        // R3 preload
        enter(0, 1, 0, "R11");
        counter = 32'd45;
        wr_data = 32'd50; wr_en = 1; cyc("R3");
        cyc("R3");
        wr_data = 32'd60; wr_en = 1; update_evt = 1; cyc("R3");
        cyc("R3");
        update_evt = 1; cyc("R3");
        counter = 32'd55; cyc("R3");

        // R6 dithering over a full cycle: integer 5, fraction 3
        enter(0, 0, 1, "R11");
        wr_data = {28'd5, 4'd3}; wr_en = 1; counter = 32'd5; cyc("R6");
        for (int k = 0; k < 17; k++) begin
            counter = 32'd5; update_evt = 1; cyc("R6");
        end
        wr_data = {28'd5, 4'd15}; wr_en = 1; cyc("R6");
        for (int k = 0; k < 16; k++) begin
            counter = 32'd5; update_evt = 1; cyc("R6");
        end

        // R7/R8/R9 capture with dithering
        enter(1, 0, 1, "R11");
        counter = 32'hDEAD_BEEF; capture_evt = 1; cyc("R8");
        cyc("R8");
        wr_data = 32'h1234_5678; wr_en = 1; cyc("R7");
        counter = 32'h0000_00FF; capture_evt = 1; cyc("R9");
        cyc("R9");
        rd_en = 1; cyc("R9");
        cyc("R9");
        counter = 32'h55; capture_evt = 1; cyc("R9");
        counter = 32'h66; capture_evt = 1; rd_en = 1; cyc("R9");
        counter = 32'h77; capture_evt = 1; cyc("R9");
        cyc("R9");
        chan_en = 0; cyc("R11");
        cyc("R11");

        enter(1, 0, 0, "R11");
        counter = 32'hABCD_0123; capture_evt = 1; wr_en = 1; wr_data = 32'h1; cyc("R7");
        cyc("R7");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 99) < 4) chan_en = ~chan_en;
            cfg_capture = 1'($urandom_range(0, 1));
            cfg_preload = 1'($urandom_range(0, 1));
            cfg_dither  = 1'($urandom_range(0, 1));
            wr_en       = ($urandom_range(0, 99) < 20);
            wr_data     = $urandom_range(0, 700);
            rd_en       = ($urandom_range(0, 99) < 20);
            update_evt  = ($urandom_range(0, 99) < 15);
            capture_evt = ($urandom_range(0, 99) < 20);
            counter     = (m_mode == 2) ? $urandom() : $urandom_range(0, 45);
            cyc("R4");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule